// File: doc/BRIEF.md
# Disk Command Block Sequencer

This block is the front end of a floppy disk controller's command path. When the host pulses a start strobe, the block reads a seven-byte command block from system memory. The read starts at a 16-bit pointer given with the strobe and moves one byte per request/acknowledge handshake. It then judges whether the command may run and either refuses it with an error code or carries it out. Head-position commands (seek and recalibrate) finish inside the block by updating a per-drive track/sector record. Data commands (read, write, format) are passed to an external transfer engine, and the block waits for that engine to report completion.

The command is judged in a fixed order. The block first checks whether the drive is ready. It then checks the track and sector bounds, whose limits depend on the drive's recording density. Last, it checks write protection for commands that alter the medium. Every command ends the same way: the block posts a result byte with a one-cycle valid pulse and raises an interrupt request, which stays high until the next command is accepted. Start strobes that arrive while a command is in progress have no effect.

Top module: `fdc_param_seq`

## Requirements
- R1: After an accepted start, the block makes exactly seven memory requests, at addresses pointer+0 through pointer+6, in that order. Only one request is outstanding at a time, and the address is held until it is acknowledged. The bytes are, in order: channel word, instruction, record count, track, sector, buffer address low, buffer address high.
- R2: After reset, busy, irq, mem_req, result_valid and xfer_start are 0, and every drive's stored track and sector read as 0.
- R3: If the drive selected by instruction bits 5..4 is not ready, the result byte is 0x80 and nothing is handed to the transfer engine.
- R4: On a double-density drive, any opcode except recalibrate posts 0x08 if any of these holds: the sector is 0, the sector is above 52, sector+count is above 53, or the track is above 76. A refused seek leaves the stored position unchanged.
- R5: On a single-density drive, the sector limit is 26, so sector+count may not exceed 27.
- R6: Recalibrate (opcode 3) skips the bounds check, stores track 0 and the given sector for its drive, and posts 0x00.
- R7: Format (opcode 2) and write (opcode 6) on a write-protected drive post 0x20. A read (opcode 4) on the same drive is handed off normally.
- R8: Only the first failing check is reported. Not-ready beats address error, and address error beats write protect.
- R9: Seek (opcode 1) stores the block's track and sector for the selected drive only, and posts 0x00.
- R10: No-op (0), verify (5) and write-deleted (7) post 0x00 with no hand-off, even on a protected drive.
- R11: Read, write and format pulse xfer_start for one cycle. The pulse comes with the channel word, instruction, count, track, sector and buffer address. The block posts 0x00 once xfer_done arrives.
- R12: A start strobe while busy is ignored. It causes no memory request and no extra result.
- R13: Every posted result comes with irq high and busy low. irq falls at the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start strobe, accepted when idle |
| pb_ptr | input | 16 | Address of the command block |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_ack | input | 1 | Memory acknowledge, one cycle, data valid |
| mem_rdata | input | 8 | Memory read data |
| drv_ready | input | 4 | Per-drive ready |
| drv_wprot | input | 4 | Per-drive write protect |
| drv_double | input | 4 | Per-drive density, 1 = double |
| xfer_start | output | 1 | One-cycle hand-off pulse to the transfer engine |
| xfer_chan | output | 8 | Channel word of the current block |
| xfer_instr | output | 8 | Instruction byte of the current block |
| xfer_count | output | 8 | Record count |
| xfer_track | output | 8 | Track |
| xfer_sector | output | 8 | First sector |
| xfer_buf | output | 16 | Buffer address |
| xfer_done | input | 1 | Transfer engine finished |
| pos_sel | input | 2 | Drive whose stored position is shown |
| pos_track | output | 8 | Stored track of the selected drive |
| pos_sector | output | 8 | Stored sector of the selected drive |
| busy | output | 1 | Command in progress |
| result_valid | output | 1 | One-cycle result pulse |
| result_byte | output | 8 | Result code, held until the next result |
| irq | output | 1 | Interrupt request |

## Verification
A fetch counter that slips by one shows up at once. The next memory address is off by one, or there are six or eight requests instead of seven. It also shifts every field, so a read aimed at sector 52 turns into an address error in the result posted a few cycles later. A wrong density choice, a swapped check order or a misrouted drive index shows up in the very next result byte. Position records are read back on pos_sel right after each seek or recalibrate, so a write to the wrong drive is caught before the next command.

// File: rtl/fdc_seq_pkg.sv
// Shared types for the disk command block sequencer.
// Assumes byte-wide memory and a seven-byte command block.
package fdc_seq_pkg;
    localparam int PB_BYTES = 7;

    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_SEEK   = 3'd1,
        OP_FORMAT = 3'd2,
        OP_RECAL  = 3'd3,
        OP_READ   = 3'd4,
        OP_VERIFY = 3'd5,
        OP_WRITE  = 3'd6,
        OP_WRDEL  = 3'd7
    } op_e;

    typedef struct packed {
        logic [7:0]  chan;
        logic [7:0]  instr;
        logic [7:0]  count;
        logic [7:0]  track;
        logic [7:0]  sector;
        logic [15:0] buffer;
    } pblock_t;

    localparam logic [7:0] RES_OK        = 8'h00;
    localparam logic [7:0] RES_ADDR_ERR  = 8'h08;
    localparam logic [7:0] RES_WPROT     = 8'h20;
    localparam logic [7:0] RES_NOT_READY = 8'h80;
endpackage

// File: rtl/pb_fetch.sv
// Command block fetcher: reads PB_BYTES bytes, one request at a time,
// from base, base+1, ... and holds them until the next launch.
// Assumes the ack is a one-cycle pulse with the data valid in that cycle.
module pb_fetch
    import fdc_seq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [ADDR_W-1:0] base,
    output logic              req,
    output logic [ADDR_W-1:0] addr,
    input  logic              ack,
    input  logic [7:0]        rdata,
    output logic              done,
    output pblock_t           blk
);
    localparam int IDX_W = $clog2(PB_BYTES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PB_BYTES - 1);

    logic              active;
    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] base_q;
    logic [7:0]        bytes_q [PB_BYTES];

    // Walk the byte index from 0 to the last byte, one step per acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            idx    <= '0;
            base_q <= '0;
        end else if (launch) begin
            active <= 1'b1;
            idx    <= '0;
            base_q <= base;
        end else if (active && ack) begin
            if (idx == LAST_IDX) begin
                active <= 1'b0;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

    // One capture register per block byte
    for (genvar g = 0; g < PB_BYTES; g++) begin : g_byte
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bytes_q[g] <= 8'h00;
            end else if (active && ack && (idx == IDX_W'(g))) begin
                bytes_q[g] <= rdata;
            end
        end
    end

    // Request/address outputs and the completion strobe
    always_comb begin
        req  = active;
        addr = base_q + ADDR_W'(idx);
        done = active && ack && (idx == LAST_IDX);
    end

    // Assemble the decoded block from the captured bytes
    always_comb begin
        blk.chan   = bytes_q[0];
        blk.instr  = bytes_q[1];
        blk.count  = bytes_q[2];
        blk.track  = bytes_q[3];
        blk.sector = bytes_q[4];
        blk.buffer = {bytes_q[6], bytes_q[5]};
    end
endmodule

// File: rtl/pb_validate.sv
// Command validator: judges a decoded command against drive state.
// Order is fixed: ready, then address bounds (skipped for recalibrate),
// then write protect for format/write. Purely combinational.
module pb_validate
    import fdc_seq_pkg::*;
#(
    parameter int N_DRV       = 4,
    parameter int SEL_W       = 2,
    parameter int LAST_SEC_DD = 52,
    parameter int LAST_SEC_SD = 26,
    parameter int LAST_TRACK  = 76
) (
    input  op_e              op,
    input  logic [SEL_W-1:0] drv,
    input  logic [7:0]       count,
    input  logic [7:0]       track,
    input  logic [7:0]       sector,
    input  logic [N_DRV-1:0] drv_ready,
    input  logic [N_DRV-1:0] drv_wprot,
    input  logic [N_DRV-1:0] drv_double,
    output logic             err,
    output logic [7:0]       code
);
    localparam logic [8:0] LIM_DD = 9'(LAST_SEC_DD);
    localparam logic [8:0] LIM_SD = 9'(LAST_SEC_SD);
    localparam logic [7:0] LIM_TR = 8'(LAST_TRACK);

    logic [8:0] last_sec;
    logic [8:0] span_end;
    logic       not_ready;
    logic       bad_addr;
    logic       wprot_hit;

    // Individual check conditions
    always_comb begin
        last_sec  = drv_double[drv] ? LIM_DD : LIM_SD;
        span_end  = {1'b0, sector} + {1'b0, count};
        not_ready = !drv_ready[drv];
        bad_addr  = (op != OP_RECAL) &&
                    ((sector == 8'h00) || ({1'b0, sector} > last_sec) ||
                     (span_end > (last_sec + 9'd1)) || (track > LIM_TR));
        wprot_hit = ((op == OP_FORMAT) || (op == OP_WRITE)) && drv_wprot[drv];
    end

    // Priority encode the first failing check
    always_comb begin
        err  = 1'b1;
        code = RES_OK;
        if (not_ready) begin
            code = RES_NOT_READY;
        end else if (bad_addr) begin
            code = RES_ADDR_ERR;
        end else if (wprot_hit) begin
            code = RES_WPROT;
        end else begin
            err = 1'b0;
        end
    end
endmodule

// File: rtl/drv_pos_file.sv
// Per-drive head position record: one track and one sector register per
// drive, written by seek/recalibrate, read combinationally by drive index.
module drv_pos_file #(
    parameter int N_DRV = 4,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [7:0]       wr_track,
    input  logic [7:0]       wr_sector,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [7:0]       rd_track,
    output logic [7:0]       rd_sector
);
    logic [7:0] trk_q [N_DRV];
    logic [7:0] sec_q [N_DRV];

    for (genvar d = 0; d < N_DRV; d++) begin : g_drv
        // Update this drive's record when it is the write target
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                trk_q[d] <= 8'h00;
                sec_q[d] <= 8'h00;
            end else if (wr_en && (wr_sel == SEL_W'(d))) begin
                trk_q[d] <= wr_track;
                sec_q[d] <= wr_sector;
            end
        end
    end

    // Read port
    always_comb begin
        rd_track  = trk_q[rd_sel];
        rd_sector = sec_q[rd_sel];
    end
endmodule

// File: rtl/fdc_param_seq.sv
// Disk command block sequencer top. Accepts a start strobe while idle,
// fetches the command block, validates it, completes position commands
// locally, hands data commands to a transfer engine, and posts a result
// byte with an interrupt request. Assumes N_DRV is a power of two.
module fdc_param_seq
    import fdc_seq_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int N_DRV       = 4,
    parameter int LAST_SEC_DD = 52,
    parameter int LAST_SEC_SD = 26,
    parameter int LAST_TRACK  = 76,
    localparam int SEL_W      = (N_DRV > 1) ? $clog2(N_DRV) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] pb_ptr,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [7:0]        mem_rdata,
    input  logic [N_DRV-1:0]  drv_ready,
    input  logic [N_DRV-1:0]  drv_wprot,
    input  logic [N_DRV-1:0]  drv_double,
    output logic              xfer_start,
    output logic [7:0]        xfer_chan,
    output logic [7:0]        xfer_instr,
    output logic [7:0]        xfer_count,
    output logic [7:0]        xfer_track,
    output logic [7:0]        xfer_sector,
    output logic [15:0]       xfer_buf,
    input  logic              xfer_done,
    input  logic [SEL_W-1:0]  pos_sel,
    output logic [7:0]        pos_track,
    output logic [7:0]        pos_sector,
    output logic              busy,
    output logic              result_valid,
    output logic [7:0]        result_byte,
    output logic              irq
);
    typedef enum logic [1:0] {S_IDLE, S_FETCH, S_CHECK, S_XFER} state_e;

    state_e           state;
    pblock_t          blk;
    logic             launch;
    logic             fetch_done;
    op_e              op;
    logic [SEL_W-1:0] drv;
    logic             chk_err;
    logic [7:0]       chk_code;
    logic             pos_wr;
    logic [7:0]       pos_wr_track;

    // Decode the fields the control path needs
    always_comb begin
        launch = (state == S_IDLE) && start;
        op     = op_e'(blk.instr[2:0]);
        drv    = blk.instr[4 +: SEL_W];
        busy   = (state != S_IDLE);
    end

    pb_fetch #(.ADDR_W(ADDR_W)) u_fetch (
        .clk   (clk),
        .rst_n (rst_n),
        .launch(launch),
        .base  (pb_ptr),
        .req   (mem_req),
        .addr  (mem_addr),
        .ack   (mem_ack),
        .rdata (mem_rdata),
        .done  (fetch_done),
        .blk   (blk)
    );

    pb_validate #(
        .N_DRV      (N_DRV),
        .SEL_W      (SEL_W),
        .LAST_SEC_DD(LAST_SEC_DD),
        .LAST_SEC_SD(LAST_SEC_SD),
        .LAST_TRACK (LAST_TRACK)
    ) u_validate (
        .op        (op),
        .drv       (drv),
        .count     (blk.count),
        .track     (blk.track),
        .sector    (blk.sector),
        .drv_ready (drv_ready),
        .drv_wprot (drv_wprot),
        .drv_double(drv_double),
        .err       (chk_err),
        .code      (chk_code)
    );

    // Position update for a clean seek or recalibrate
    always_comb begin
        pos_wr       = (state == S_CHECK) && !chk_err &&
                       ((op == OP_SEEK) || (op == OP_RECAL));
        pos_wr_track = (op == OP_RECAL) ? 8'h00 : blk.track;
    end

    drv_pos_file #(.N_DRV(N_DRV), .SEL_W(SEL_W)) u_pos (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (pos_wr),
        .wr_sel   (drv),
        .wr_track (pos_wr_track),
        .wr_sector(blk.sector),
        .rd_sel   (pos_sel),
        .rd_track (pos_track),
        .rd_sector(pos_sector)
    );

    // Command sequencing, result posting and interrupt request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= S_IDLE;
            result_valid <= 1'b0;
            result_byte  <= RES_OK;
            irq          <= 1'b0;
            xfer_start   <= 1'b0;
        end else begin
            result_valid <= 1'b0;
            xfer_start   <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        state <= S_FETCH;
                        irq   <= 1'b0;
                    end
                end
                S_FETCH: begin
                    if (fetch_done) begin
                        state <= S_CHECK;
                    end
                end
                S_CHECK: begin
                    if (chk_err) begin
                        result_byte  <= chk_code;
                        result_valid <= 1'b1;
                        irq          <= 1'b1;
                        state        <= S_IDLE;
                    end else if ((op == OP_READ) || (op == OP_WRITE) ||
                                 (op == OP_FORMAT)) begin
                        xfer_start <= 1'b1;
                        state      <= S_XFER;
                    end else begin
                        result_byte  <= RES_OK;
                        result_valid <= 1'b1;
                        irq          <= 1'b1;
                        state        <= S_IDLE;
                    end
                end
                S_XFER: begin
                    if (xfer_done) begin
                        result_byte  <= RES_OK;
                        result_valid <= 1'b1;
                        irq          <= 1'b1;
                        state        <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Hand-off fields straight from the captured block
    always_comb begin
        xfer_chan   = blk.chan;
        xfer_instr  = blk.instr;
        xfer_count  = blk.count;
        xfer_track  = blk.track;
        xfer_sector = blk.sector;
        xfer_buf    = blk.buffer;
    end
endmodule

// File: rtl/fdc_param_seq_chk.sv
// Protocol checker for the command block sequencer, bound to the top.
module fdc_param_seq_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack,
    input logic              busy,
    input logic              xfer_start,
    input logic [7:0]        xfer_instr,
    input logic              result_valid,
    input logic              irq
);
    // R1
    req_in_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    // R1
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R1
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> (!mem_req || (mem_addr == $past(mem_addr) + 1'b1)));

    // R11
    xfer_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> ((xfer_instr[2:0] == 3'd2) || (xfer_instr[2:0] == 3'd4) ||
                        (xfer_instr[2:0] == 3'd6)));

    // R11
    xfer_waits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> busy);

    // R12
    no_refetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_req) |=> !mem_req);

    // R13
    post_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> (irq && !busy));

    // R11
    one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({xfer_start, result_valid}));
endmodule

bind fdc_param_seq fdc_param_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_ack     (mem_ack),
    .busy        (busy),
    .xfer_start  (xfer_start),
    .xfer_instr  (xfer_instr),
    .result_valid(result_valid),
    .irq         (irq)
);

// File: tb/test_fdc_param_seq.sv
// Scoreboard bench: the driver queues expected results, the monitor
// compares them with posted results; memory and transfer engine are modelled.
module test_fdc_param_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] pb_ptr = '0;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic [3:0]  drv_ready  = 4'b0111;
    logic [3:0]  drv_wprot  = 4'b0100;
    logic [3:0]  drv_double = 4'b1110;
    logic        xfer_start;
    logic [7:0]  xfer_chan, xfer_instr, xfer_count, xfer_track, xfer_sector;
    logic [15:0] xfer_buf;
    logic        xfer_done = 1'b0;
    logic [1:0]  pos_sel = '0;
    logic [7:0]  pos_track, pos_sector;
    logic        busy, result_valid, irq;
    logic [7:0]  result_byte;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fdc_param_seq i_fdc_param_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .pb_ptr(pb_ptr),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .drv_ready(drv_ready), .drv_wprot(drv_wprot), .drv_double(drv_double),
        .xfer_start(xfer_start), .xfer_chan(xfer_chan), .xfer_instr(xfer_instr),
        .xfer_count(xfer_count), .xfer_track(xfer_track), .xfer_sector(xfer_sector),
        .xfer_buf(xfer_buf), .xfer_done(xfer_done),
        .pos_sel(pos_sel), .pos_track(pos_track), .pos_sector(pos_sector),
        .busy(busy), .result_valid(result_valid), .result_byte(result_byte), .irq(irq)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0]  mem [256];
    logic [15:0] addr_log [1024];
    int          nlog = 0;
    int          lat = 0;
    int          xfer_cnt = 0;
    int          posted = 0;
    bit          xfer_seen = 1'b0;
    logic [7:0]  cap_chan, cap_instr, cap_count, cap_track, cap_sector;
    logic [15:0] cap_buf;
    logic [7:0]  exp_res_q [$];
    bit          exp_xfer_q [$];
    string       exp_tag_q [$];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Memory model, transfer engine model and result monitor
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack = 1'b0;
            xfer_done = 1'b0;
        end else begin
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                if (lat >= 1) begin
                    mem_ack   = 1'b1;
                    mem_rdata = mem[mem_addr[7:0]];
                    addr_log[nlog] = mem_addr;
                    nlog++;
                    lat = 0;
                end else begin
                    lat++;
                end
            end
            xfer_done = 1'b0;
            if (xfer_cnt > 0) begin
                xfer_cnt--;
                if (xfer_cnt == 0) xfer_done = 1'b1;
            end
            if (xfer_start) begin
                xfer_seen = 1'b1;
                xfer_cnt  = 3;
                cap_chan = xfer_chan; cap_instr = xfer_instr; cap_count = xfer_count;
                cap_track = xfer_track; cap_sector = xfer_sector; cap_buf = xfer_buf;
            end
            if (result_valid) begin
                if (exp_res_q.size() == 0) begin
                    chk("R12 unexpected result", 32'(result_byte), 32'hFFFF);
                end else begin
                    automatic logic [7:0] er = exp_res_q.pop_front();
                    automatic bit ex = exp_xfer_q.pop_front();
                    automatic string tg = exp_tag_q.pop_front();
                    chk({tg, " result"}, 32'(result_byte), 32'(er));
                    chk({tg, " hand-off"}, 32'(xfer_seen), 32'(ex));
                    chk("R13 irq with result", 32'({irq, busy}), 32'b10);
                end
                xfer_seen = 1'b0;
                posted++;
            end
        end
    end

    function automatic logic [7:0] mk_instr(input logic [1:0] d, input logic [2:0] op);
        return {2'b00, d, 1'b0, op};
    endfunction

    task automatic run_cmd(input string tag, input logic [15:0] p, input logic [7:0] instr,
                           input logic [7:0] cnt, input logic [7:0] trk, input logic [7:0] sec,
                           input logic [15:0] bufa, input logic [7:0] exp_res,
                           input bit exp_x, input bit intrude);
        int log0;
        int p0;
        bit ok;
        mem[p[7:0]]        = 8'h5A;
        mem[p[7:0] + 8'd1] = instr;
        mem[p[7:0] + 8'd2] = cnt;
        mem[p[7:0] + 8'd3] = trk;
        mem[p[7:0] + 8'd4] = sec;
        mem[p[7:0] + 8'd5] = bufa[7:0];
        mem[p[7:0] + 8'd6] = bufa[15:8];
        exp_res_q.push_back(exp_res);
        exp_xfer_q.push_back(exp_x);
        exp_tag_q.push_back(tag);
        log0 = nlog;
        p0   = posted;
        @(negedge clk);
        start  = 1'b1;
        pb_ptr = p;
        @(negedge clk);
        start  = 1'b0;
        pb_ptr = 16'hFFF0;
        chk("R13 irq cleared on start", 32'({irq, busy}), 32'b01);
        if (intrude) begin
            repeat (6) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            while (!xfer_start) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (posted == p0) @(negedge clk);
        @(negedge clk);
        if (intrude) repeat (30) @(negedge clk);
        chk("R1 request count", 32'(nlog - log0), 32'd7);
        chk("R12 single result", 32'(posted - p0), 32'd1);
        ok = 1'b1;
        for (int k = 0; k < 7; k++) begin
            if (addr_log[log0 + k] !== p + 16'(k)) ok = 1'b0;
        end
        chk("R1 address order", 32'(ok), 32'd1);
        if (exp_x) begin
            chk("R11 hand-off chan/instr", {16'h0, cap_chan, cap_instr}, {16'h0, 8'h5A, instr});
            chk("R11 hand-off count/track/sector", {8'h0, cap_count, cap_track, cap_sector},
                {8'h0, cnt, trk, sec});
            chk("R11 hand-off buffer", 32'(cap_buf), 32'(bufa));
        end
    endtask

    task automatic chk_pos(input string tag, input logic [1:0] d, input logic [7:0] trk,
                           input logic [7:0] sec);
        pos_sel = d;
        #1;
        chk(tag, {16'h0, pos_track, pos_sector}, {16'h0, trk, sec});
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    // Watchdog: a hung run is a failed check
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        summary();
        $finish;
    end

    // Stimulus
    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (4) @(negedge clk);
        // R2 reset state
        chk("R2 reset outputs", 32'({busy, irq, mem_req, result_valid, xfer_start}), 32'd0);
        chk_pos("R2 reset position d1", 2'd1, 8'h00, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 seek updates only its drive
        run_cmd("R9 seek d1", 16'h1A40, mk_instr(2'd1, 3'd1), 8'd1, 8'd40, 8'd10, 16'h0, 8'h00, 1'b0, 1'b0);
        chk_pos("R9 pos d1", 2'd1, 8'd40, 8'd10);
        chk_pos("R9 pos d0 untouched", 2'd0, 8'd0, 8'd0);

        // R4 double-density bounds
        run_cmd("R4 read sec52", 16'h2080, mk_instr(2'd1, 3'd4), 8'd1, 8'd3, 8'd52, 16'h4000, 8'h00, 1'b1, 1'b0);
        run_cmd("R4 read sec53", 16'h20A0, mk_instr(2'd1, 3'd4), 8'd1, 8'd3, 8'd53, 16'h4000, 8'h08, 1'b0, 1'b0);
        run_cmd("R4 span 54", 16'h20B0, mk_instr(2'd1, 3'd4), 8'd4, 8'd3, 8'd50, 16'h4000, 8'h08, 1'b0, 1'b0);
        run_cmd("R4 span 53", 16'h20C0, mk_instr(2'd1, 3'd4), 8'd3, 8'd3, 8'd50, 16'h4100, 8'h00, 1'b1, 1'b0);
        run_cmd("R4 track 77", 16'h20D0, mk_instr(2'd1, 3'd4), 8'd1, 8'd77, 8'd1, 16'h4000, 8'h08, 1'b0, 1'b0);
        run_cmd("R4 track 76", 16'h20E0, mk_instr(2'd1, 3'd4), 8'd1, 8'd76, 8'd1, 16'h4200, 8'h00, 1'b1, 1'b0);
        run_cmd("R4 sector 0", 16'h20F0, mk_instr(2'd1, 3'd4), 8'd1, 8'd2, 8'd0, 16'h4000, 8'h08, 1'b0, 1'b0);
        run_cmd("R4 refused seek", 16'h2010, mk_instr(2'd1, 3'd1), 8'd1, 8'd9, 8'd60, 16'h0, 8'h08, 1'b0, 1'b0);
        chk_pos("R4 pos unchanged", 2'd1, 8'd40, 8'd10);

        // R5 single-density bounds on drive 0
        run_cmd("R5 seek sec27", 16'h3000, mk_instr(2'd0, 3'd1), 8'd1, 8'd5, 8'd27, 16'h0, 8'h08, 1'b0, 1'b0);
        run_cmd("R5 seek sec26", 16'h3010, mk_instr(2'd0, 3'd1), 8'd1, 8'd5, 8'd26, 16'h0, 8'h00, 1'b0, 1'b0);
        chk_pos("R5 pos d0", 2'd0, 8'd5, 8'd26);
        run_cmd("R5 format span 27", 16'h3020, mk_instr(2'd0, 3'd2), 8'd26, 8'd7, 8'd1, 16'h5000, 8'h00, 1'b1, 1'b0);

        // R6 recalibrate skips bounds
        run_cmd("R6 recal", 16'h3040, mk_instr(2'd1, 3'd3), 8'd0, 8'd99, 8'd0, 16'h0, 8'h00, 1'b0, 1'b0);
        chk_pos("R6 pos d1", 2'd1, 8'd0, 8'd0);

        // R3 and R8 ordering
        run_cmd("R3 seek not ready", 16'h3060, mk_instr(2'd3, 3'd1), 8'd1, 8'd1, 8'd1, 16'h0, 8'h80, 1'b0, 1'b0);
        run_cmd("R8 not ready over address", 16'h3070, mk_instr(2'd3, 3'd4), 8'd1, 8'd1, 8'd0, 16'h0, 8'h80, 1'b0, 1'b0);
        run_cmd("R8 address over protect", 16'h3080, mk_instr(2'd2, 3'd6), 8'd1, 8'd1, 8'd0, 16'h0, 8'h08, 1'b0, 1'b0);

        // R7 write protect
        run_cmd("R7 write protected", 16'h3090, mk_instr(2'd2, 3'd6), 8'd1, 8'd1, 8'd1, 16'h0, 8'h20, 1'b0, 1'b0);
        run_cmd("R7 format protected", 16'h30A0, mk_instr(2'd2, 3'd2), 8'd1, 8'd1, 8'd1, 16'h0, 8'h20, 1'b0, 1'b0);
        run_cmd("R7 read protected ok", 16'h30B0, mk_instr(2'd2, 3'd4), 8'd2, 8'd10, 8'd7, 16'h6000, 8'h00, 1'b1, 1'b0);

        // R11 write hand-off
        run_cmd("R11 write d1", 16'h30C0, mk_instr(2'd1, 3'd6), 8'd2, 8'd11, 8'd5, 16'hBEEF, 8'h00, 1'b1, 1'b0);

        // R10 local completions
        run_cmd("R10 nop", 16'h30D0, mk_instr(2'd1, 3'd0), 8'd1, 8'd1, 8'd1, 16'h0, 8'h00, 1'b0, 1'b0);
        run_cmd("R10 verify", 16'h30E0, mk_instr(2'd1, 3'd5), 8'd1, 8'd1, 8'd1, 16'h0, 8'h00, 1'b0, 1'b0);
        run_cmd("R10 write-deleted", 16'h30F0, mk_instr(2'd2, 3'd7), 8'd1, 8'd1, 8'd1, 16'h0, 8'h00, 1'b0, 1'b0);

        // R12 start strobes while busy
        run_cmd("R12 busy ignore", 16'h3100, mk_instr(2'd1, 3'd4), 8'd1, 8'd12, 8'd3, 16'h7000, 8'h00, 1'b1, 1'b1);
        chk("R12 idle after", 32'({busy, mem_req}), 32'd0);

        summary();
        $finish;
    end
endmodule